// File: doc/BRIEF.md
# Sliced Wide Counter and Programmable Divider

This block builds a wide synchronous up-counter out of identical narrow slices, four slices of eight bits by default, which gives 32 bits. Every slice raises an active-low "all ones" flag. A slice above the lowest one advances only when every slice below it is all ones. Its enable is the OR of those lower flags, so a carry crosses any number of slices in a single clock edge. All slices share one clock and one asynchronous reset.

The mode input picks one of two behaviours. In count mode the full word counts freely and wraps from all ones to zero. In divide mode, the OR of every slice flag drives the parallel load of all slices. The chain therefore reloads from the preset word only when the whole width is all ones. The chain terminal count output goes low for one clock in each period, and the period is 2^W minus the preset. A global enable freezes the whole chain, including any reload.

Top module: `wide_divider_chain`

## Requirements
- R1: The asynchronous reset sets `count` to zero at once, without a clock edge. After reset `tc_n` is high.
- R2: In count mode, with `cnt_en` high, every rising clock edge adds one to the full-width `count`, modulo 2^W.
- R3: A slice above the lowest one changes only on an enabled edge where every lower slice is all ones. On any other edge it holds its value.
- R4: `tc_n` is low exactly when every bit of `count` is one.
- R5: While `cnt_en` is low, `count` holds on every edge in both modes. This includes the all-ones state in divide mode, where no reload happens.
- R6: In divide mode, the enabled edge that follows an all-ones `count` loads the full `preset` word into `count`.
- R7: In divide mode, `tc_n` goes low once every 2^W − `preset` enabled cycles. A preset of zero gives a period of 2^W. A preset of all ones keeps `tc_n` low on every cycle.
- R8: In count mode, an all-ones `count` wraps to zero on the next enabled edge and does not load `preset`.
- R9: `preset` is sampled only on a reload edge. Changing it at any other time does not affect `count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all slices |
| rst_a | input | 1 | Asynchronous reset, active high |
| cnt_en | input | 1 | Global enable, active high; low freezes the chain |
| div_mode | input | 1 | 0 = free count, 1 = programmable divide |
| preset | input | SLICE_W*SLICES | Reload word used in divide mode |
| count | output | SLICE_W*SLICES | Full-width counter value |
| tc_n | output | 1 | Chain terminal count, active low, low at all ones |

## Verification
The hardest state to reach from the ports is the first reload. Reset clears the chain, and nothing loads a preset until the whole width has counted up to all ones, which takes 2^W − 1 cycles. The bench therefore builds the chain with narrow 3-bit slices, four of them. This keeps the more-than-two-slice OR gating in place while making a full traversal only 4096 cycles long. Once that wrap is reached, the bench chooses presets that sit just below slice boundaries. This forces carries through one, two and three slices on a single edge, and it also checks the extreme ratios of one and 2^W.

// File: rtl/wide_divider_chain.sv
module wide_divider_chain #(
  parameter int SLICE_W = 8,
  parameter int SLICES  = 4,
  localparam int W = SLICE_W * SLICES
) (
  input  logic         clk,
  input  logic         rst_a,
  input  logic         cnt_en,
  input  logic         div_mode,
  input  logic [W-1:0] preset,
  output logic [W-1:0] count,
  output logic         tc_n
);

  localparam logic [SLICE_W-1:0] ONE = SLICE_W'(1);

  logic [SLICES-1:0] slice_tc_n;
  logic [SLICES-1:0] slice_ce_n;
  logic              load_n;

  assign tc_n   = |slice_tc_n;
  assign load_n = ~div_mode | tc_n;

  for (genvar g = 0; g < SLICES; g++) begin : g_slice
    logic [SLICE_W-1:0] q;

    assign slice_tc_n[g] = ~&q;
    assign count[g*SLICE_W +: SLICE_W] = q;

    if (g == 0) begin : g_lsb
      assign slice_ce_n[g] = ~cnt_en;
    end else begin : g_upper
      assign slice_ce_n[g] = ~cnt_en | (|slice_tc_n[g-1:0]);

      // R3: an upper slice moves only when all lower slices are all ones
      assert_slice_hold_R3: assert property (@(posedge clk) disable iff (rst_a)
        (!(&count[g*SLICE_W-1:0]) && !(div_mode && &count))
          |=> $stable(count[g*SLICE_W +: SLICE_W]));
    end

    always_ff @(posedge clk or posedge rst_a) begin
      if (rst_a)                 q <= '0;
      else if (cnt_en && !load_n) q <= preset[g*SLICE_W +: SLICE_W];
      else if (!slice_ce_n[g])   q <= q + ONE;
    end
  end

  // R1: reset leaves a zero count
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst_a |-> (count == '0 && tc_n));

  // R5: disabled chain freezes
  assert_freeze_R5: assert property (@(posedge clk) disable iff (rst_a)
    !cnt_en |=> $stable(count));

  // R2 / R8: count mode increments and wraps
  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst_a)
    (cnt_en && !div_mode) |=> count == $past(count) + W'(1));

  // R6: reload of the full preset word at all ones
  assert_reload_R6: assert property (@(posedge clk) disable iff (rst_a)
    (cnt_en && div_mode && &count) |=> count == $past(preset));

  // R9: preset ignored away from the reload edge
  assert_no_early_load_R9: assert property (@(posedge clk) disable iff (rst_a)
    (cnt_en && div_mode && !(&count)) |=> count == $past(count) + W'(1));

endmodule

// File: tb/wide_divider_chain_tb.sv
module wide_divider_chain_tb;
  localparam int SW = 3;
  localparam int NS = 4;
  localparam int W  = SW * NS;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_a = 1'b1;
  logic cnt_en = 1'b0;
  logic div_mode = 1'b0;
  logic [W-1:0] preset = '0;
  logic [W-1:0] count;
  logic tc_n;

  logic [W-1:0] m = '0;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  wide_divider_chain #(.SLICE_W(SW), .SLICES(NS)) u_dut (
    .clk(clk), .rst_a(rst_a), .cnt_en(cnt_en), .div_mode(div_mode),
    .preset(preset), .count(count), .tc_n(tc_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    if (cnt_en) m = (div_mode && (&m)) ? preset : m + W'(1);
    #1;
    chk(count === m, tag, count, m);
    chk(tc_n === ~&m, "R4", W'(tc_n), W'(~&m));
  endtask

  task automatic t_reset;
    #1;
    chk(count === '0, "R1", count, '0);
    chk(tc_n === 1'b1, "R1", W'(tc_n), W'(1));
    @(negedge clk) rst_a = 1'b0;
  endtask

  task automatic t_free_wrap;
    div_mode = 1'b0; cnt_en = 1'b1;
    for (int i = 0; i < (1 << W) + 8; i++) begin
      step("R2");
      if (m == ONES) begin
        chk(tc_n === 1'b0, "R4", W'(tc_n), '0);
        step("R8");
        chk(count === '0, "R8", count, '0);
      end
    end
  endtask

  task automatic t_async_reset;
    #3 rst_a = 1'b1;
    #1 chk(count === '0, "R1", count, '0);
    m = '0;
    @(negedge clk) rst_a = 1'b0;
  endtask

  task automatic reach_top(input string tag);
    while (m != ONES) step(tag);
  endtask

  task automatic t_divide(input logic [W-1:0] p);
    int k;
    div_mode = 1'b1; cnt_en = 1'b1; preset = p;
    reach_top("R3");
    k = 0;
    do begin
      step("R6");
      k++;
    end while (m != ONES);
    chk(k == (1 << W) - int'(p), "R7", W'(k), W'((1 << W) - int'(p)));
  endtask

  task automatic t_hold_at_top;
    div_mode = 1'b1; cnt_en = 1'b1; preset = 12'h3F0;
    reach_top("R3");
    cnt_en = 1'b0;
    for (int i = 0; i < 6; i++) step("R5");
    chk(count === ONES, "R5", count, ONES);
    cnt_en = 1'b1;
    step("R6");
    chk(count === 12'h3F0, "R6", count, 12'h3F0);
    cnt_en = 1'b0;
    for (int i = 0; i < 4; i++) step("R5");
    cnt_en = 1'b1;
  endtask

  task automatic t_preset_change;
    div_mode = 1'b1; cnt_en = 1'b1; preset = 12'hF00;
    reach_top("R3");
    step("R6");
    for (int i = 0; i < 20; i++) begin
      preset = W'(i * 97);
      step("R9");
    end
    chk(count === 12'hF14, "R9", count, 12'hF14);
    preset = 12'hABC;
    reach_top("R9");
    step("R6");
    chk(count === 12'hABC, "R6", count, 12'hABC);
  endtask

  initial begin
    #1_500_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_free_wrap();
    for (int i = 0; i < 37; i++) step("R2");
    t_async_reset();
    t_divide(12'hE3F);
    t_divide(12'hFF9);
    t_divide(12'h1C7);
    t_divide(ONES);
    t_divide(12'h000);
    t_hold_at_top();
    t_preset_change();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule